// File: doc/BRIEF.md
# Correlator-Bank Peak-Picking Symbol Demodulator

This block turns one symbol's worth of correlator outputs into data bits. Each symbol presents a bank of signed correlation values for the in-phase channel and another for the quadrature channel. The block finds the strongest correlator in each channel by absolute value and keeps that correlator's position and polarity. A phase reference bit, taken from the final bit of the received header, fixes the absolute phase. When that reference is set, both polarities are flipped.

A rate select chooses between two data word formats. The narrow format carries one nibble per symbol. The wide format carries two nibbles per symbol. The word is shifted out serially toward the descrambler, one bit per clock, with a valid flag. The block holds one symbol at a time. A new strobe is accepted once the word in flight is on its final bit, which allows gapless back-to-back symbols. A strobe that arrives earlier is dropped and flagged.

Top module: `bmo_demod`

## Requirements
- R1: After reset, `bit_valid_o` and `overrun_o` are both 0.
- R2: The I-channel pick is the correlator with the largest absolute value. When magnitudes tie, the lowest index wins.
- R3: The Q-channel pick is made on its own, under the same largest-magnitude, lowest-index rule as the I channel.
- R4: Comparison uses absolute value. A picked correlator's sign bit is 1 when its value is negative, so -5 beats +4 and gives sign 1.
- R5: When `hdr_ref_i` is 1, both the I and Q sign bits are inverted before they enter the word.
- R6: With `wide_mode_i`=0, only correlators 0..3 of each channel compete. The word is 4 bits: bits[1:0] are the I index, bit 2 is the I sign and bit 3 is the Q sign.
- R7: With `wide_mode_i`=1, all 8 correlators compete. The word is 8 bits: bits[2:0] are the I index, bit 3 is the I sign, bits[6:4] are the Q index and bit 7 is the Q sign.
- R8: Bits leave least significant first, one per clock, with `bit_valid_o` high. The first bit appears in the cycle after the strobe is sampled, and `bit_valid_o` falls after the last bit.
- R9: A strobe sampled while more than one bit of the current word remains raises `overrun_o` for one cycle. That symbol is dropped and the current word finishes unchanged.
- R10: A strobe sampled while the final bit is on the output is accepted. Its first bit follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | One-cycle strobe: correlator values are valid |
| corr_i_i | input | 8x12 | I-channel correlator values, signed |
| corr_q_i | input | 8x12 | Q-channel correlator values, signed |
| hdr_ref_i | input | 1 | Polarity of the last header bit (1 inverts the signs) |
| wide_mode_i | input | 1 | 0: one nibble per symbol, 1: two nibbles per symbol |
| bit_o | output | 1 | Serial data bit |
| bit_valid_o | output | 1 | `bit_o` carries data |
| overrun_o | output | 1 | One-cycle pulse: a strobe was dropped |

## Verification
The hardest situations to reach from the ports are the edges of the acceptance window. A strobe that lands on the final output bit must be taken without a gap. A strobe that lands one bit earlier must be refused while the running word continues untouched. The bench counts clock edges from the first strobe and raises the second strobe at exact negedges inside the serialization. It then checks every bit across the boundary. Magnitude corner cases are driven with chosen values: a tie, the most negative code against the most positive one, and large values placed in the upper correlators during narrow mode.

// File: rtl/bmo_pkg.sv
package bmo_pkg;
  localparam int unsigned N_CORR_DEF = 8;
  localparam int unsigned CORR_W_DEF = 12;

  typedef enum logic {
    RATE_ONE_NIB = 1'b0,
    RATE_TWO_NIB = 1'b1
  } rate_e;
endpackage

// File: rtl/bmo_peak_pick.sv
module bmo_peak_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 12,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] corr_i,
  input  logic                half_i,
  output logic [IW-1:0]       idx_o,
  output logic                neg_o
);
  logic [N-1:0][W-1:0] mag;

  // unsigned magnitude; the most negative code maps onto 2^(W-1)
  for (genvar g = 0; g < N; g++) begin : g_mag
    assign mag[g] = corr_i[g][W-1] ? (~corr_i[g] + 1'b1) : corr_i[g];
  end

  logic [W-1:0]  best_mag;
  logic [IW-1:0] best_idx;

  always_comb begin
    best_mag = mag[0];
    best_idx = '0;
    for (int k = 1; k < N; k++) begin
      // strict compare: ties keep the lower index
      if ((!half_i || (k < N / 2)) && (mag[k] > best_mag)) begin
        best_mag = mag[k];
        best_idx = IW'(k);
      end
    end
  end

  assign idx_o = best_idx;
  assign neg_o = corr_i[best_idx][W-1];
endmodule

// File: rtl/bmo_word_pack.sv
module bmo_word_pack
  import bmo_pkg::*;
#(
  parameter int unsigned IW     = 3,
  localparam int unsigned WORD_W = 2 * (IW + 1),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic [IW-1:0]     idx_i_i,
  input  logic              neg_i_i,
  input  logic [IW-1:0]     idx_q_i,
  input  logic              neg_q_i,
  input  logic              hdr_ref_i,
  input  rate_e             rate_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  nbits_o
);
  logic sgn_i, sgn_q;

  assign sgn_i = neg_i_i ^ hdr_ref_i;
  assign sgn_q = neg_q_i ^ hdr_ref_i;

  always_comb begin
    if (rate_i == RATE_TWO_NIB) begin
      word_o  = {sgn_q, idx_q_i, sgn_i, idx_i_i};
      nbits_o = CNT_W'(WORD_W);
    end else begin
      word_o  = WORD_W'({sgn_q, sgn_i, idx_i_i[IW-2:0]});
      nbits_o = CNT_W'(IW + 1);
    end
  end
endmodule

// File: rtl/bmo_serializer.sv
module bmo_serializer #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_req_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic              overrun_o,
  output logic [CNT_W-1:0]  left_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept, refuse;

  assign accept = load_req_i && (cnt_q <= CNT_W'(1));
  assign refuse = load_req_i && (cnt_q >  CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      cnt_q     <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= refuse;
      if (accept) begin
        shreg_q <= word_i;
        cnt_q   <= nbits_i;
      end else if (cnt_q != '0) begin
        shreg_q <= shreg_q >> 1;
        cnt_q   <= cnt_q - 1'b1;
      end
    end
  end

  assign bit_o       = shreg_q[0];
  assign bit_valid_o = (cnt_q != '0);
  assign left_o      = cnt_q;
endmodule

// File: rtl/bmo_demod.sv
module bmo_demod
  import bmo_pkg::*;
#(
  parameter int unsigned N_CORR = N_CORR_DEF,
  parameter int unsigned CORR_W = CORR_W_DEF,
  localparam int unsigned IW     = $clog2(N_CORR),
  localparam int unsigned WORD_W = 2 * (IW + 1),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sym_valid_i,
  input  logic [N_CORR-1:0][CORR_W-1:0] corr_i_i,
  input  logic [N_CORR-1:0][CORR_W-1:0] corr_q_i,
  input  logic                          hdr_ref_i,
  input  logic                          wide_mode_i,
  output logic                          bit_o,
  output logic                          bit_valid_o,
  output logic                          overrun_o
);
  rate_e             rate;
  logic [IW-1:0]     idx_i, idx_q;
  logic              neg_i, neg_q;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  nbits;
  logic [CNT_W-1:0]  bits_left;

  assign rate = wide_mode_i ? RATE_TWO_NIB : RATE_ONE_NIB;

  bmo_peak_pick #(.N(N_CORR), .W(CORR_W)) u_pick_i (
    .corr_i (corr_i_i),
    .half_i (rate == RATE_ONE_NIB),
    .idx_o  (idx_i),
    .neg_o  (neg_i)
  );

  bmo_peak_pick #(.N(N_CORR), .W(CORR_W)) u_pick_q (
    .corr_i (corr_q_i),
    .half_i (rate == RATE_ONE_NIB),
    .idx_o  (idx_q),
    .neg_o  (neg_q)
  );

  bmo_word_pack #(.IW(IW)) u_pack (
    .idx_i_i   (idx_i),
    .neg_i_i   (neg_i),
    .idx_q_i   (idx_q),
    .neg_q_i   (neg_q),
    .hdr_ref_i (hdr_ref_i),
    .rate_i    (rate),
    .word_o    (word),
    .nbits_o   (nbits)
  );

  bmo_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_req_i  (sym_valid_i),
    .word_i      (word),
    .nbits_i     (nbits),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .overrun_o   (overrun_o),
    .left_o      (bits_left)
  );
endmodule

// File: rtl/bmo_demod_chk.sv
module bmo_demod_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned NB_LO = 4,
  parameter int unsigned NB_HI = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sym_valid_i,
  input logic             wide_mode_i,
  input logic             bit_valid_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] bits_left
);
  a_r9_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && bits_left > CNT_W'(1)) |=> overrun_o);

  a_r9_no_false_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sym_valid_i && bits_left > CNT_W'(1)) |=> !overrun_o);

  a_r8_first_bit_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && bits_left <= CNT_W'(1)) |=> bit_valid_o);

  a_r6_narrow_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && bits_left <= CNT_W'(1) && !wide_mode_i) |=> (bits_left == CNT_W'(NB_LO)));

  a_r7_wide_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && bits_left <= CNT_W'(1) && wide_mode_i) |=> (bits_left == CNT_W'(NB_HI)));

  a_r9_drain_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_left > CNT_W'(1)) |=> (bits_left == $past(bits_left) - CNT_W'(1)));
endmodule

bind bmo_demod bmo_demod_chk #(
  .CNT_W (CNT_W),
  .NB_LO (IW + 1),
  .NB_HI (WORD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .wide_mode_i (wide_mode_i),
  .bit_valid_o (bit_valid_o),
  .overrun_o   (overrun_o),
  .bits_left   (bits_left)
);

// File: tb/tb_bmo_demod.sv
`timescale 1ns/1ps
module tb_bmo_demod;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            sym_valid_i = 1'b0;
  logic [7:0][11:0] corr_i_i, corr_q_i;
  logic            hdr_ref_i = 1'b0;
  logic            wide_mode_i = 1'b0;
  logic            bit_o, bit_valid_o, overrun_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  bmo_demod dut (
    .clk_i, .rst_ni, .sym_valid_i, .corr_i_i, .corr_q_i,
    .hdr_ref_i, .wide_mode_i, .bit_o, .bit_valid_o, .overrun_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int vi, input int vq);
    for (int k = 0; k < 8; k++) begin
      corr_i_i[k] = 12'(vi);
      corr_q_i[k] = 12'(vq);
    end
  endtask

  // strobe at a negedge, then check every bit at following negedges
  task automatic run_word(input logic [7:0] exp, input int nb, input string req);
    sym_valid_i = 1'b1;
    @(posedge clk_i);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk_i);
      sym_valid_i = 1'b0;
      chk(bit_valid_o === 1'b1, {req, " valid"}, int'(bit_valid_o), 1);
      chk(bit_o === exp[b], {req, " bit"}, int'(bit_o), int'(exp[b]));
    end
    @(negedge clk_i);
    chk(bit_valid_o === 1'b0, {req, " R8 valid end"}, int'(bit_valid_o), 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(bit_valid_o === 1'b0, "R1 valid", int'(bit_valid_o), 0);
    chk(overrun_o === 1'b0, "R1 overrun", int'(overrun_o), 0);
  endtask

  task automatic t_wide_basic();
    fill(100, 20);
    corr_i_i[5] = 12'(-300);
    corr_q_i[2] = 12'(250);
    wide_mode_i = 1'b1; hdr_ref_i = 1'b0;
    run_word(8'h2D, 8, "R7 R8 wide");
  endtask

  task automatic t_ties();
    fill(10, 10);
    corr_i_i[1] = 12'(500); corr_i_i[6] = 12'(500);
    corr_q_i[3] = 12'(-400); corr_q_i[7] = 12'(400);
    wide_mode_i = 1'b1; hdr_ref_i = 1'b0;
    run_word(8'hB1, 8, "R2 R3 tie");
  endtask

  task automatic t_abs_ref();
    fill(3, 4);
    corr_i_i[0] = 12'(-2048); corr_i_i[4] = 12'(2047);
    corr_q_i[6] = 12'(-5);
    wide_mode_i = 1'b1; hdr_ref_i = 1'b1;
    run_word(8'h60, 8, "R4 R5 abs ref");
  endtask

  task automatic t_narrow(input bit ref_bit, input logic [7:0] exp, input string req);
    fill(10, 10);
    corr_i_i[7] = 12'(900); corr_i_i[2] = 12'(-300);
    corr_q_i[5] = 12'(-900); corr_q_i[1] = 12'(200);
    wide_mode_i = 1'b0; hdr_ref_i = ref_bit;
    run_word(exp, 4, req);
  endtask

  task automatic t_back_to_back();
    logic [15:0] exp;
    exp = 16'hB1_2D;
    fill(100, 20);
    corr_i_i[5] = 12'(-300); corr_q_i[2] = 12'(250);
    wide_mode_i = 1'b1; hdr_ref_i = 1'b0;
    sym_valid_i = 1'b1;
    @(posedge clk_i);
    for (int b = 0; b < 16; b++) begin
      @(negedge clk_i);
      sym_valid_i = 1'b0;
      chk(bit_valid_o === 1'b1, "R10 valid", int'(bit_valid_o), 1);
      chk(bit_o === exp[b], "R10 bit", int'(bit_o), int'(exp[b]));
      if (b == 7) begin
        fill(10, 10);
        corr_i_i[1] = 12'(500); corr_i_i[6] = 12'(500);
        corr_q_i[3] = 12'(-400); corr_q_i[7] = 12'(400);
        sym_valid_i = 1'b1;
      end
      if (b == 8) chk(overrun_o === 1'b0, "R10 no overrun", int'(overrun_o), 0);
    end
    @(negedge clk_i);
    chk(bit_valid_o === 1'b0, "R10 valid end", int'(bit_valid_o), 0);
  endtask

  task automatic t_overrun();
    logic [7:0] exp;
    exp = 8'h2D;
    fill(100, 20);
    corr_i_i[5] = 12'(-300); corr_q_i[2] = 12'(250);
    wide_mode_i = 1'b1; hdr_ref_i = 1'b0;
    sym_valid_i = 1'b1;
    @(posedge clk_i);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk_i);
      sym_valid_i = 1'b0;
      chk(bit_o === exp[b] && bit_valid_o === 1'b1, "R9 kept bit", int'(bit_o), int'(exp[b]));
      if (b == 3) chk(overrun_o === 1'b1, "R9 flag", int'(overrun_o), 1);
      else        chk(overrun_o === 1'b0, "R9 flag low", int'(overrun_o), 0);
      if (b == 2) begin
        fill(7, 7);
        corr_i_i[0] = 12'(-999);
        sym_valid_i = 1'b1;
      end
    end
    @(negedge clk_i);
    chk(bit_valid_o === 1'b0, "R9 dropped", int'(bit_valid_o), 0);
  endtask

  initial begin
    fill(0, 0);
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_wide_basic();
    t_ties();
    t_abs_ref();
    t_narrow(1'b0, 8'h06, "R6 narrow");
    t_narrow(1'b1, 8'h0A, "R5 R6 narrow ref");
    t_back_to_back();
    t_overrun();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule